// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts cycles of a slow, always-on clock. Software must service it before the counter reaches the end of the selected period. The first time a period ends without a service, the block raises a non-maskable interrupt request. The interrupt handler then has one more full period to recover. If that second period also ends without a service, the block raises a reset request that the chip's reset logic uses as one of its reset sources.

A service is a two-write key sequence on a byte-wide write port. A wrong byte drops the sequence, so a runaway program cannot service the watchdog with a single stray store. Four period lengths are available, each four times the one before it. The shortest length is a parameter; at a 32 kHz clock the default gives 125 ms, 500 ms, 2 s and 8 s. A new period choice is adopted only at a service or when a reset pulse ends, so a stray write to the select lines cannot shorten or stretch the period that is already running.

The control state machine has three states. In RUN the counter advances and no request is raised. ALERT holds the interrupt request. HOLD drives the reset request for a fixed number of clocks. The transitions are:
- RUN to ALERT on an overflow.
- ALERT to RUN on a valid service.
- ALERT to HOLD on a second overflow.
- HOLD to RUN once the hold count expires; this exit also clears the whole block.

A valid service keeps the block in RUN, and an unserviced ALERT stays in ALERT until the next overflow.

Top module: `wdt_two_stage`

## Requirements
- R1: While `rst_n` is low and right after it rises, `nmi_req` and `rst_req` are low. The counter starts from zero and select 0 (the shortest period) is in force.
- R2: The period is 2^(SHORT_LOG2 + 2*s) clocks for select value s in 0..3. An overflow is detected exactly that many clock edges after reset release, after a valid service, or after the end of a reset hold.
- R3: The first overflow moves RUN to ALERT. `nmi_req` rises on that edge and stays high until a valid service or the next overflow.
- R4: A second overflow with no service in between moves ALERT to HOLD. On that edge `rst_req` rises and `nmi_req` falls.
- R5: `rst_req` stays high for exactly RST_HOLD clocks. The block then returns to RUN with the counter cleared, and the next `nmi_req` comes one full period later.
- R6: A service is a write cycle (`svc_wr`=1) of byte 0x5A followed by a write of byte 0xA5. Cycles without a write may come between the two. After 0x5A, a further 0x5A keeps the sequence armed. Any byte other than 0x5A or 0xA5 in the armed state, and any byte other than 0x5A in the idle state, leaves the sequence idle.
- R7: A valid service clears the counter and, in ALERT, returns the block to RUN, with `nmi_req` low from the next edge.
- R8: `period_sel` is sampled only on a valid service and at the end of a reset hold. Changing it at any other time does not change the running period.
- R9: Writes during HOLD are ignored: they neither service the block nor shorten the reset pulse.
- R10: `nmi_req` and `rst_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lsi | input | 1 | Low-speed always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 2 | Period choice, adopted on service or at the end of a hold |
| svc_wr | input | 1 | Write strobe of the service port |
| svc_data | input | 8 | Key byte of the service port |
| nmi_req | output | 1 | Non-maskable interrupt request (ALERT) |
| rst_req | output | 1 | System reset request (HOLD) |

## Verification
The hardest situation to reach is the exit from HOLD, because the block first has to run two full unserviced periods back to back. The bench therefore uses a shortest period of four clocks, which lets it step through every period select from overflow to interrupt to reset and back to RUN. At the end of each hold it checks that the next interrupt comes one full period later. Key writes are aimed at exact cycles to test several cases: a service while the reset pulse is high, a wrong byte in the middle of a sequence, and a repeated first key.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ALERT = 2'd1,
        ST_HOLD  = 2'd2
    } wdt2_state_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } wdt2_key_e;

    localparam logic [7:0] KEY_OPEN  = 8'h5A;
    localparam logic [7:0] KEY_CLOSE = 8'hA5;
endpackage

// File: rtl/wdt2_key_seq.sv
module wdt2_key_seq
    import wdt2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       svc_ok
);
    wdt2_key_e key_q, key_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= KEY_IDLE;
        else        key_q <= key_d;
    end

    always_comb begin
        key_d  = key_q;
        svc_ok = 1'b0;
        if (flush) begin
            key_d = KEY_IDLE;
        end else if (wr_en) begin
            unique case (key_q)
                KEY_IDLE:  key_d = (wr_data == KEY_OPEN) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: begin
                    if (wr_data == KEY_CLOSE) begin
                        svc_ok = 1'b1;
                        key_d  = KEY_IDLE;
                    end else if (wr_data == KEY_OPEN) begin
                        key_d = KEY_ARMED;
                    end else begin
                        key_d = KEY_IDLE;
                    end
                end
                default: key_d = KEY_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdt2_period_ctr.sv
module wdt2_period_ctr #(
    parameter int SHORT_LOG2 = 12,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             reload,
    input  logic [SEL_W-1:0] sel_in,
    output logic             ovf
);
    localparam int NUM_SEL = 1 << SEL_W;
    localparam int CNT_W   = SHORT_LOG2 + 2 * (NUM_SEL - 1);

    logic [CNT_W-1:0] limit_tab [NUM_SEL];
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    generate
        for (genvar g = 0; g < NUM_SEL; g++) begin : g_limit
            localparam int SH = SHORT_LOG2 + 2 * g;
            assign limit_tab[g] = CNT_W'((64'd1 << SH) - 64'd1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (reload) sel_q <= sel_in;
    end

    assign at_limit = (cnt_q == limit_tab[sel_q]);
    assign ovf      = at_limit && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear || at_limit) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt2_pkg::*;
#(
    parameter int SHORT_LOG2 = 12,
    parameter int RST_HOLD   = 16
) (
    input  logic       clk_lsi,
    input  logic       rst_n,
    input  logic [1:0] period_sel,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       nmi_req,
    output logic       rst_req
);
    localparam int HOLD_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);

    wdt2_state_e      state_q, state_d;
    logic [HOLD_W-1:0] hold_q;
    logic             in_hold, hold_done, svc_ok, ovf;

    assign in_hold   = (state_q == ST_HOLD);
    assign hold_done = in_hold && (hold_q == HOLD_LAST);

    wdt2_key_seq u_key (
        .clk     (clk_lsi),
        .rst_n   (rst_n),
        .flush   (in_hold),
        .wr_en   (svc_wr),
        .wr_data (svc_data),
        .svc_ok  (svc_ok)
    );

    wdt2_period_ctr #(
        .SHORT_LOG2 (SHORT_LOG2),
        .SEL_W      (2)
    ) u_ctr (
        .clk    (clk_lsi),
        .rst_n  (rst_n),
        .clear  (svc_ok || in_hold),
        .reload (svc_ok || hold_done),
        .sel_in (period_sel),
        .ovf    (ovf)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (ovf) state_d = ST_ALERT;
            ST_ALERT: begin
                if (svc_ok)   state_d = ST_RUN;
                else if (ovf) state_d = ST_HOLD;
            end
            ST_HOLD:  if (hold_done) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_lsi or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= in_hold ? hold_q + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk_lsi or negedge rst_n) begin
        if (!rst_n) begin
            nmi_req <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            nmi_req <= (state_d == ST_ALERT);
            rst_req <= (state_d == ST_HOLD);
        end
    end
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker #(
    parameter int RST_HOLD = 16
) (
    input logic clk,
    input logic rst_n,
    input logic nmi_req,
    input logic rst_req,
    input logic svc_ok,
    input logic ovf
);
    int unsigned width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) width_q <= 0;
        else        width_q <= rst_req ? width_q + 1 : 0;
    end

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req && rst_req));

    assert_rst_after_nmi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(nmi_req));

    assert_nmi_on_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !nmi_req && !rst_req) |=> nmi_req);

    assert_service_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !nmi_req);

    assert_hold_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (width_q < RST_HOLD));

    assert_hold_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> ($past(width_q) == RST_HOLD - 1));

    assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !svc_ok);
endmodule

bind wdt_two_stage wdt2_checker #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk     (clk_lsi),
    .rst_n   (rst_n),
    .nmi_req (nmi_req),
    .rst_req (rst_req),
    .svc_ok  (svc_ok),
    .ovf     (ovf)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb_top;
    localparam int SHORT = 2;
    localparam int HOLD  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       nmi_req, rst_req;

    int edge_n = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    wdt_two_stage #(.SHORT_LOG2(SHORT), .RST_HOLD(HOLD)) dut_i (
        .clk_lsi(clk), .rst_n(rst_n), .period_sel(period_sel),
        .svc_wr(svc_wr), .svc_data(svc_data),
        .nmi_req(nmi_req), .rst_req(rst_req)
    );

    function automatic int per(int s);
        return 1 << (SHORT + 2 * s);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(output int base);
        @(negedge clk);
        rst_n = 1'b0; svc_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 nmi in reset", int'(nmi_req), 0);
        chk("R1 rst in reset", int'(rst_req), 0);
        rst_n = 1'b1;
        base = edge_n;
    endtask

    task automatic wr(logic [7:0] b);
        svc_wr = 1'b1; svc_data = b;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic service(output int e);
        wr(8'h5A); wr(8'hA5); e = edge_n;
    endtask

    task automatic wait_nmi(output int e);
        while (!nmi_req) @(negedge clk);
        e = edge_n;
    endtask

    task automatic wait_rst(output int e);
        while (!rst_req) @(negedge clk);
        e = edge_n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int b, e, t, w;
        // sweep every period select through the full escalation
        for (int s = 0; s < 4; s++) begin
            period_sel = 2'd3;
            do_reset(b);
            wait_nmi(t);
            chk("R1 default select 0 period", t - b, per(0));
            period_sel = 2'(s);
            service(e);
            chk("R7 nmi cleared by service", int'(nmi_req), 0);
            wait_nmi(t);
            chk("R2 first overflow period", t - e, per(s));
            wait_rst(e);
            chk("R4 second overflow period", e - t, per(s));
            w = 0;
            while (rst_req) begin
                if (nmi_req) chk("R10 nmi low during hold", 1, 0);
                w++; @(negedge clk);
            end
            chk("R5 reset hold width", w, HOLD);
            e = edge_n;
            wait_nmi(t);
            chk("R5 next nmi after hold", t - e, per(s));
        end

        // R3: nmi stays high until next overflow
        period_sel = 2'd1;
        do_reset(b);
        service(e);
        wait_nmi(t);
        repeat (per(1) - 1) @(negedge clk);
        chk("R3 nmi held", int'(nmi_req), 1);
        chk("R3 no reset yet", int'(rst_req), 0);

        // R8: select change without service is ignored
        do_reset(b);
        period_sel = 2'd1;
        service(e);
        period_sel = 2'd3;
        wait_nmi(t);
        chk("R8 select change ignored", t - e, per(1));

        // R6: wrong byte mid sequence drops it
        period_sel = 2'd2;
        do_reset(b);
        service(e);
        wr(8'h5A); wr(8'h33); wr(8'hA5);
        wait_nmi(t);
        chk("R6 wrong key no service", t - e, per(2));

        // R6: repeated open key and idle gap still service
        do_reset(b);
        service(e);
        repeat (5) @(negedge clk);
        wr(8'h5A); wr(8'h5A);
        repeat (2) @(negedge clk);
        wr(8'hA5);
        e = edge_n;
        wait_nmi(t);
        chk("R6 armed key retained", t - e, per(2));

        // R9: key during hold ignored
        period_sel = 2'd0;
        do_reset(b);
        wait_rst(e);
        wr(8'h5A); wr(8'hA5);
        while (rst_req) @(negedge clk);
        chk("R9 hold not shortened", edge_n - e, HOLD);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule